// File: doc/BRIEF.md
# Grouped Interrupt Expansion Multiplexer

This block gathers a large set of peripheral interrupt request lines and folds them onto a small number of CPU interrupt inputs. The sources are split into equal groups, and each group drives one CPU line. Every source keeps a pending flag, which a rising edge of its request sets, and an individual enable bit. It also has a vector word that software loads through a simple write-only register bus.

When the CPU takes a group line, it pulses an acknowledge together with the group number. The block looks for the lowest-numbered source in that group that is both pending and enabled. It returns that source's vector on the next clock, clears that source's flag and sets the group's acknowledge bit. While the acknowledge bit is set, the group's CPU line is held low. It stays low until software writes a one to the matching bit of the acknowledge-clear register. The answer arrives one cycle after the acknowledge, well inside the eight-cycle window the CPU spends on its vector fetch and register save.

The default build has 12 groups of 8 sources, 96 in all, with 16-bit vectors.

Top module: `gie_mux`

## Requirements
- R1: While reset is held, and right after reset, every `cpu_int` bit is 0, `vec_valid` is 0 and `vec_data` is 0. All enable bits and all group acknowledge bits are also 0.
- R2: A source's flag is set only by a 0-to-1 change of its request line. A request held high sets the flag once. After that flag is serviced, the source raises no new request until its line goes low and then high again.
- R3: Source number g*SRC_PER_GRP+k is bit k of group g. `cpu_int[g]` is 1 exactly when some source of group g is both flagged and enabled and the group's acknowledge bit is 0.
- R4: A bus write to address NUM_SRC+g loads the enable bits of group g from `bus_wdata[SRC_PER_GRP-1:0]`, with bit k enabling source k of that group. A disabled source still records its flag. Enabling it later raises the group line.
- R5: If `cpu_ack` is 1 and `cpu_ack_grp` is below NUM_GROUPS at a clock edge, `vec_valid` is 1 for exactly the next cycle. In that cycle, `vec_data` carries the vector of the lowest-numbered flagged and enabled source of that group. That source's flag is cleared, and the flags of all other sources are kept.
- R6: An in-range acknowledge of a group with no flagged and enabled source still gives `vec_valid`, with `vec_data` equal to 0. It clears no flag.
- R7: An in-range acknowledge sets the group's acknowledge bit, so `cpu_int[g]` is 0 from the next cycle on. A bus write to address NUM_SRC+NUM_GROUPS clears the acknowledge bit of every group whose data bit is 1. Data bits that are 0 leave their groups unchanged.
- R8: A bus write to an address s below NUM_SRC stores `bus_wdata` as the vector of source s.
- R9: An acknowledge with `cpu_ack_grp` at or above NUM_GROUPS has no effect. It gives no `vec_valid`, clears no flag and sets no acknowledge bit.
- R10: If a source's request rises in the same cycle that an acknowledge clears its flag, the flag stays set.
- R11: Outside the cycle that follows an acknowledge, `vec_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | NUM_SRC | Peripheral request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (vectors, enable registers, acknowledge-clear register) |
| bus_wdata | input | VEC_W | Register write data |
| cpu_ack | input | 1 | CPU acknowledge pulse |
| cpu_ack_grp | input | GRP_W | Group being acknowledged |
| cpu_int | output | NUM_GROUPS | One interrupt line per group |
| vec_valid | output | 1 | Vector answer strobe |
| vec_data | output | VEC_W | Vector of the serviced source |

## Verification
Each result has a fixed latency. A request edge that the block samples at a clock edge raises the group line right after that edge. An enable or acknowledge-clear write changes the line right after the edge that captures the write. The vector answer and the group line dropping both appear right after the edge that samples the acknowledge. The bench drives all inputs just after a falling edge and samples at the next falling edge, half a cycle after the capturing edge, so every line check lands on the first cycle its result is due. Each acknowledge pushes its expected vector into a queue. A monitor pops an entry for every cycle with `vec_valid` high, so a missing answer, an extra answer or a wrong vector is caught in the cycle it occurs.

// File: rtl/gie_pkg.sv
package gie_pkg;
  // Which part of the register space a bus address falls into.
  typedef enum logic [1:0] {
    RGN_VEC  = 2'd0,
    RGN_EN   = 2'd1,
    RGN_ACK  = 2'd2,
    RGN_NONE = 2'd3
  } gie_rgn_e;
endpackage

// File: rtl/gie_rst_sync.sv
module gie_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/gie_vec_ram.sv
module gie_vec_ram #(
  parameter int DEPTH = 96,
  parameter int W     = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Storage cells carry no reset; software loads them before use.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/gie_group.sv
module gie_group #(
  parameter int SRC_N = 8,
  parameter int IDX_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] req_i,
  input  logic             en_we_i,
  input  logic [SRC_N-1:0] en_wdata_i,
  input  logic             take_i,
  input  logic             ack_clr_i,
  output logic             int_o,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o
);
  logic [SRC_N-1:0] req_q, flag_q, en_q;
  logic             ack_q;
  logic [SRC_N-1:0] rise, pend, clr_mask, flag_d;
  logic             ack_d;

  // Next-state logic
  always_comb begin
    rise      = req_i & ~req_q;
    pend      = flag_q & en_q;
    win_vld_o = |pend;
    win_idx_o = '0;
    // Scan downward so the lowest pending index is the one left standing.
    for (int k = SRC_N - 1; k >= 0; k--) begin
      if (pend[k]) win_idx_o = IDX_W'(k);
    end
    clr_mask = '0;
    if (take_i && win_vld_o) clr_mask[win_idx_o] = 1'b1;
    // A new edge wins over a clear in the same cycle.
    flag_d = (flag_q & ~clr_mask) | rise;
    if (take_i)         ack_d = 1'b1;
    else if (ack_clr_i) ack_d = 1'b0;
    else                ack_d = ack_q;
    int_o = win_vld_o & ~ack_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      req_q  <= req_i;
      flag_q <= flag_d;
      ack_q  <= ack_d;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end
endmodule

// File: rtl/gie_mux.sv
module gie_mux
  import gie_pkg::*;
#(
  parameter int  NUM_GROUPS  = 12,
  parameter int  SRC_PER_GRP = 8,
  parameter int  VEC_W       = 16,
  localparam int NUM_SRC     = NUM_GROUPS * SRC_PER_GRP,
  localparam int GRP_W       = $clog2(NUM_GROUPS),
  localparam int ADDR_W      = $clog2(NUM_SRC + NUM_GROUPS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    irq_src,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [VEC_W-1:0]      bus_wdata,
  input  logic                  cpu_ack,
  input  logic [GRP_W-1:0]      cpu_ack_grp,
  output logic [NUM_GROUPS-1:0] cpu_int,
  output logic                  vec_valid,
  output logic [VEC_W-1:0]      vec_data
);
  localparam int IDX_W    = $clog2(SRC_PER_GRP);
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int EN_BASE  = NUM_SRC;
  localparam int ACK_ADDR = NUM_SRC + NUM_GROUPS;

  logic                  rst_int_n;
  gie_rgn_e              rgn;
  logic                  ram_we;
  logic                  ack_ok;
  logic [GRP_W-1:0]      grp_safe;
  logic [NUM_GROUPS-1:0] en_we, take, ack_clr, win_vld;
  logic [IDX_W-1:0]      win_idx [NUM_GROUPS];
  logic                  sel_vld;
  logic [IDX_W-1:0]      sel_idx;
  logic [SRC_W-1:0]      raddr;
  logic [VEC_W-1:0]      rdata;
  logic                  vec_valid_d;
  logic [VEC_W-1:0]      vec_data_d;

  gie_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Address decode and acknowledge qualification
  always_comb begin
    if (int'(bus_addr) < NUM_SRC)        rgn = RGN_VEC;
    else if (int'(bus_addr) < ACK_ADDR)  rgn = RGN_EN;
    else if (int'(bus_addr) == ACK_ADDR) rgn = RGN_ACK;
    else                                 rgn = RGN_NONE;
    ram_we   = bus_wr && (rgn == RGN_VEC);
    ack_ok   = cpu_ack && (int'(cpu_ack_grp) < NUM_GROUPS);
    grp_safe = (int'(cpu_ack_grp) < NUM_GROUPS) ? cpu_ack_grp : '0;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign en_we[g]   = bus_wr && (rgn == RGN_EN) && (int'(bus_addr) == EN_BASE + g);
    assign take[g]    = ack_ok && (int'(cpu_ack_grp) == g);
    assign ack_clr[g] = bus_wr && (rgn == RGN_ACK) && bus_wdata[g];

    gie_group #(.SRC_N(SRC_PER_GRP), .IDX_W(IDX_W)) u_grp (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .req_i      (irq_src[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .en_we_i    (en_we[g]),
      .en_wdata_i (bus_wdata[SRC_PER_GRP-1:0]),
      .take_i     (take[g]),
      .ack_clr_i  (ack_clr[g]),
      .int_o      (cpu_int[g]),
      .win_vld_o  (win_vld[g]),
      .win_idx_o  (win_idx[g])
    );
  end

  // Winner of the acknowledged group selects the vector word.
  always_comb begin
    sel_vld = win_vld[grp_safe];
    sel_idx = win_idx[grp_safe];
    raddr   = SRC_W'(int'(grp_safe) * SRC_PER_GRP + int'(sel_idx));
  end

  gie_vec_ram #(.DEPTH(NUM_SRC), .W(VEC_W), .AW(SRC_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (SRC_W'(bus_addr)),
    .wdata (bus_wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  // Vector answer: next state
  always_comb begin
    vec_valid_d = ack_ok;
    vec_data_d  = vec_data;
    if (ack_ok) vec_data_d = sel_vld ? rdata : '0;
  end

  // Vector answer: registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= vec_valid_d;
      vec_data  <= vec_data_d;
    end
  end
endmodule

// File: rtl/gie_mux_chk.sv
module gie_mux_chk #(
  parameter int  NUM_GROUPS  = 12,
  parameter int  SRC_PER_GRP = 8,
  parameter int  VEC_W       = 16,
  localparam int NUM_SRC     = NUM_GROUPS * SRC_PER_GRP,
  localparam int GRP_W       = $clog2(NUM_GROUPS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_ack,
  input logic [GRP_W-1:0]      cpu_ack_grp,
  input logic [NUM_GROUPS-1:0] cpu_int,
  input logic                  vec_valid,
  input logic [VEC_W-1:0]      vec_data
);
  logic             ok_ack;
  logic [GRP_W-1:0] grp_q;

  assign ok_ack = cpu_ack && (int'(cpu_ack_grp) < NUM_GROUPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_q <= '0;
    else        grp_q <= cpu_ack_grp;
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (cpu_int == '0 && !vec_valid && vec_data == '0);
    end
  end

  // R5
  ack_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_ack |=> vec_valid);

  // R9
  stray_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_ack |=> !vec_valid);

  // R7
  line_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_ack |=> !cpu_int[grp_q]);

  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_ack |=> $stable(vec_data));
endmodule

bind gie_mux gie_mux_chk #(
  .NUM_GROUPS  (NUM_GROUPS),
  .SRC_PER_GRP (SRC_PER_GRP),
  .VEC_W       (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_ack     (cpu_ack),
  .cpu_ack_grp (cpu_ack_grp),
  .cpu_int     (cpu_int),
  .vec_valid   (vec_valid),
  .vec_data    (vec_data)
);

// File: tb/sim_gie_mux.sv
`timescale 1ns/1ps
module sim_gie_mux;
  localparam int NG     = 12;
  localparam int SPG    = 8;
  localparam int VW     = 16;
  localparam int NS     = NG * SPG;
  localparam int GW     = $clog2(NG);
  localparam int AW     = $clog2(NS + NG + 1);
  localparam int ACK_AD = NS + NG;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] irq_src;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [VW-1:0] bus_wdata;
  logic          cpu_ack;
  logic [GW-1:0] cpu_ack_grp;
  logic [NG-1:0] cpu_int;
  logic          vec_valid;
  logic [VW-1:0] vec_data;

  int total = 0;
  int fails = 0;
  bit done  = 0;
  logic [VW-1:0] exp_q [$];
  string         tag_q [$];
  logic [VW-1:0] last_vec;

  gie_mux #(.NUM_GROUPS(NG), .SRC_PER_GRP(SPG), .VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cpu_ack(cpu_ack),
    .cpu_ack_grp(cpu_ack_grp), .cpu_int(cpu_int), .vec_valid(vec_valid),
    .vec_data(vec_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [VW-1:0] vexp(int s);
    return VW'((s * 16'h0123) ^ 16'h8000);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(int addr, logic [VW-1:0] data);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic pulse(int s);
    irq_src[s] = 1'b1;
    tick();
    irq_src[s] = 1'b0;
  endtask

  // Driver: acknowledge a group and push the expected answer.
  task automatic do_ack(int g, logic [VW-1:0] exp, string tag);
    cpu_ack = 1'b1; cpu_ack_grp = GW'(g);
    if (g < NG) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    tick();
    cpu_ack = 1'b0;
  endtask

  // Monitor: compare each answer against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done && vec_valid) begin
      if (exp_q.size() == 0) begin
        total++; fails++;
        $display("FAIL R9: actual vector %0h expected no answer", vec_data);
      end else begin
        chk(tag_q.pop_front(), {16'h0, vec_data}, {16'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_src = '0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; cpu_ack = 1'b0; cpu_ack_grp = '0;
    repeat (4) tick();
    // R1: outputs quiet during reset
    chk("R1", {20'h0, cpu_int}, 32'h0);
    chk("R1", {31'h0, vec_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1", {20'h0, cpu_int}, 32'h0);
    chk("R1", {16'h0, vec_data}, 32'h0);

    // R8: load every vector
    for (int s = 0; s < NS; s++) bus_write(s, vexp(s));

    // R4: a disabled source flags but does not raise its line
    pulse(3);
    chk("R4", {31'h0, cpu_int[0]}, 32'h0);
    bus_write(NS + 0, 16'h00FF);
    chk("R4", {31'h0, cpu_int[0]}, 32'h1);
    pulse(5);
    // R5 / R8: lowest index first
    do_ack(0, vexp(3), "R5");
    chk("R7", {31'h0, cpu_int[0]}, 32'h0);
    bus_write(ACK_AD, 16'h0000);
    chk("R7", {31'h0, cpu_int[0]}, 32'h0);
    bus_write(ACK_AD, 16'h0001);
    chk("R3", {31'h0, cpu_int[0]}, 32'h1);
    do_ack(0, vexp(5), "R5");
    bus_write(ACK_AD, 16'h0001);
    chk("R5", {31'h0, cpu_int[0]}, 32'h0);

    // R2: a held request flags only once
    bus_write(NS + 1, 16'h00FF);
    irq_src[10] = 1'b1;
    tick();
    chk("R2", {31'h0, cpu_int[1]}, 32'h1);
    do_ack(1, vexp(10), "R2");
    bus_write(ACK_AD, 16'h0002);
    tick();
    chk("R2", {31'h0, cpu_int[1]}, 32'h0);
    irq_src[10] = 1'b0;
    tick();
    pulse(10);
    chk("R2", {31'h0, cpu_int[1]}, 32'h1);
    do_ack(1, vexp(10), "R2");
    bus_write(ACK_AD, 16'h0002);

    // R6: empty group answers zero
    do_ack(2, 16'h0000, "R6");
    bus_write(ACK_AD, 16'h0004);
    chk("R6", {20'h0, cpu_int}, 32'h0);

    // R9: out-of-range acknowledge
    bus_write(NS + 11, 16'h00FF);
    pulse(95);
    do_ack(15, 16'h0, "R9");
    chk("R9", {31'h0, vec_valid}, 32'h0);
    chk("R9", {31'h0, cpu_int[11]}, 32'h1);
    do_ack(11, vexp(95), "R9");
    bus_write(ACK_AD, 16'h0800);
    chk("R9", {31'h0, cpu_int[11]}, 32'h0);

    // R10: edge in the clearing cycle keeps the flag
    pulse(88);
    tick();
    irq_src[88] = 1'b1;
    do_ack(11, vexp(88), "R10");
    irq_src[88] = 1'b0;
    bus_write(ACK_AD, 16'h0800);
    chk("R10", {31'h0, cpu_int[11]}, 32'h1);
    do_ack(11, vexp(88), "R10");
    bus_write(ACK_AD, 16'h0800);
    chk("R10", {31'h0, cpu_int[11]}, 32'h0);

    // R5 / R4: priority order with one source masked
    bus_write(NS + 5, 16'h00FD);
    pulse(47); pulse(44); pulse(41);
    do_ack(5, vexp(44), "R5");
    bus_write(ACK_AD, 16'h0020);
    do_ack(5, vexp(47), "R5");
    bus_write(ACK_AD, 16'h0020);
    chk("R4", {31'h0, cpu_int[5]}, 32'h0);
    bus_write(NS + 5, 16'h00FF);
    chk("R4", {31'h0, cpu_int[5]}, 32'h1);
    do_ack(5, vexp(41), "R5");
    last_vec = vexp(41);
    bus_write(ACK_AD, 16'h0020);

    // R11: vector holds while idle
    repeat (3) tick();
    chk("R11", {16'h0, vec_data}, {16'h0, last_vec});
    chk("R11", {31'h0, vec_valid}, 32'h0);
    chk("R3", {20'h0, cpu_int}, 32'h0);
    chk("R5", exp_q.size(), 32'h0);

    finish_run();
  end
endmodule